// File: doc/BRIEF.md
# Dispatch Controller with Skid Buffer

This block sits between the register-rename stage and the issue and memory-ordering queues of an out-of-order core, for one hardware thread. Every cycle it receives a group of up to `REN_W` renamed instructions, each with a tag and a set of class flags. It decides how many of them go onward in this cycle and which queue port each uses. It keeps a five-valued status (idle, running, blocked, unblocking, squashing) and sends single-cycle block and release handshakes back to rename.

When the thread cannot dispatch, because of a stall from commit, a full or stalled queue, or more arrivals than the dispatch width, the arriving instructions are parked in a skid buffer. On resumption the buffer is drained oldest first, ahead of anything new. A squash from commit empties both the buffer and the current input group. Every instruction removed that way, dispatched or dropped, is reported in the per-cycle counts so that rename can return its credits. The queues themselves are outside the block and appear only as full flags and insert strobes.

Top module: `disp_skid_ctrl`

## Requirements
- R1: After reset the status output reads idle and all strobes, pulses and counts are zero. The status codes are idle=0, running=1, blocked=2, unblocking=3, squashing=4.
- R2: Valid input lanes are contiguous from lane 0. At most `ISSUE_W` instructions are examined per cycle, and they fill dispatch slots from slot 0 in arrival order. An idle thread becomes running once it dispatches an instruction.
- R3: Each examined instruction that is not squashed is routed as follows. Class flag bit order for the bench is {squashed, load, store, store-conditional, non-speculative, no-op}. A load goes to the load/store port and the issue port. A store goes to the load/store port and also to the non-speculative port when store-conditional, otherwise to the issue port. Otherwise a non-speculative instruction goes to the non-speculative port. Otherwise a no-op raises only the completion strobe. Any other instruction goes to the issue port.
- R4: A squashed instruction raises no strobe but counts as dispatched. It also counts toward the memory count when its load or store flag is set.
- R5: When more instructions arrive than fit in one cycle while running or idle, the surplus enters the skid buffer, the block pulse is raised, the status becomes blocked, and the release pulse is held low in that cycle.
- R6: Any of the held commit stall, issue-queue full, load/store-queue full or load/store-queue stalled blocks the thread. The whole input group is parked and nothing is dispatched. The block pulse is raised only if the status was neither blocked nor unblocking.
- R7: The commit stall is set by a commit block pulse and cleared by a commit release pulse, and release wins when both arrive together. A release pulse with no stall held and no block pulse in the same cycle is illegal.
- R8: A blocked thread with no stall moves to unblocking and takes its instructions from the skid buffer, oldest first. New arrivals are appended behind the buffer, and a non-empty remainder returns the status to blocked. Once the buffer and the input are both empty, the release pulse is raised and the status becomes running.
- R9: A commit squash has top priority. It flushes the skid buffer and the input group, and reports every flushed entry in the dispatched count and each flushed load or store in the memory count. It raises the release pulse only if the status was blocked or unblocking, sets squashing, and dispatches nothing.
- R10: While the reorder buffer reports it is still squashing, the status is squashing, nothing is dispatched, and arriving instructions are dropped but counted.
- R11: A squashing thread with no squash, no reorder-buffer squash and no stall returns to running and dispatches in that same cycle.
- R12: The skid buffer holds 3 x `REN_DLY` x `REN_W` + `ISSUE_W` entries and its occupancy never exceeds that.
- R13: All outputs are registered and reflect the inputs of the previous clock edge. Counts and strobes are zero in a cycle that dispatches, drops and flushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_vld | input | REN_W | Lane valid, contiguous from lane 0 |
| i_tag | input | REN_W*TAG_W | Instruction tag per lane |
| i_sq | input | REN_W | Instruction already squashed |
| i_ld | input | REN_W | Load |
| i_st | input | REN_W | Store |
| i_sc | input | REN_W | Store-conditional (with i_st) |
| i_ns | input | REN_W | Non-speculative |
| i_nop | input | REN_W | No-op |
| i_iq_full | input | 1 | Issue queue full |
| i_lsq_full | input | 1 | Load/store queue full |
| i_lsq_stall | input | 1 | Load/store queue stalled |
| i_cmt_block | input | 1 | Commit block pulse |
| i_cmt_unblock | input | 1 | Commit release pulse |
| i_cmt_squash | input | 1 | Commit squash |
| i_rob_squashing | input | 1 | Reorder buffer still squashing |
| o_iq_ins | output | ISSUE_W | Issue-queue insert strobe per slot |
| o_ns_ins | output | ISSUE_W | Non-speculative insert strobe per slot |
| o_lsq_ins | output | ISSUE_W | Load/store-queue insert strobe per slot |
| o_nop_done | output | ISSUE_W | Completed-at-dispatch strobe per slot |
| o_slot_tag | output | ISSUE_W*TAG_W | Tag per slot |
| o_block | output | 1 | Block pulse to rename |
| o_unblock | output | 1 | Release pulse to rename |
| o_disp_cnt | output | CNT_W | Instructions dispatched or dropped this cycle |
| o_mem_cnt | output | CNT_W | Loads and stores among them |
| o_state | output | 3 | Thread status code |

## Verification
Routing is swept over all 64 combinations of class flags on a single instruction while running. This separates the priority among load, store, store-conditional, non-speculative and no-op, and it shows that the squashed flag overrides every route while the memory count still follows load and store. Groups wider than the dispatch width, stalls from each source, and a buffer filled exactly to capacity then drained check slot order tag by tag. They also distinguish buffer-first draining and appending from dispatching straight off the input. Squash and reorder-buffer squash are applied with a loaded buffer and while running, which tells apart the flush counts and when the release pulse fires.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } dsp_state_e;

  // bit 5 .. bit 0
  typedef struct packed {
    logic sq;
    logic ld;
    logic st;
    logic sc;
    logic ns;
    logic nop;
  } cls_t;

  localparam int CLS_W = 6;

  typedef struct packed {
    logic iq;
    logic ns;
    logic lsq;
    logic done;
    logic mem;
  } route_t;

  function automatic int skid_cap(int dly, int ren_w, int iss_w);
    return 3 * dly * ren_w + iss_w;
  endfunction

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic route_t route_of(logic vld, cls_t c);
    route_t r;
    r = '0;
    r.mem = vld & (c.ld | c.st);
    if (vld && !c.sq) begin
      if (c.ld) begin
        r.lsq = 1'b1;
        r.iq  = 1'b1;
      end else if (c.st) begin
        r.lsq = 1'b1;
        if (c.sc) r.ns = 1'b1;
        else      r.iq = 1'b1;
      end else if (c.ns) begin
        r.ns = 1'b1;
      end else if (c.nop) begin
        r.done = 1'b1;
      end else begin
        r.iq = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/dsp_stall.sv
`timescale 1ns/1ps
module dsp_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_p,
  input  logic unblk_p,
  output logic flag_now,
  output logic flag_q
);
  // release wins over block in the same cycle
  always_comb begin
    if (unblk_p)    flag_now = 1'b0;
    else if (blk_p) flag_now = 1'b1;
    else            flag_now = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_now;
  end
endmodule

// File: rtl/dsp_skid.sv
`timescale 1ns/1ps
module dsp_skid
  import dsp_pkg::*;
#(
  parameter int DEPTH  = 14,
  parameter int PUSH_W = 4,
  parameter int POP_W  = 2,
  parameter int E_W    = 14,
  parameter int CNT_W  = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [CNT_W-1:0]            pop_n,
  input  logic [CNT_W-1:0]            push_n,
  input  logic [PUSH_W-1:0][E_W-1:0]  push_data,
  output logic [POP_W-1:0][E_W-1:0]   peek,
  output logic [CNT_W-1:0]            count,
  output logic [CNT_W-1:0]            mem_cnt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [E_W-1:0]   slot_q [DEPTH];
  logic [IDX_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] wrap(int base, int off);
    return IDX_W'((base + off) % DEPTH);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= wrap(int'(head_q), int'(pop_n));
      cnt_q  <= cnt_q - pop_n + push_n;
    end
  end

  // tail sits at head+count; a pop in the same cycle does not move it
  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int i = 0; i < PUSH_W; i++) begin
        if (i < int'(push_n))
          slot_q[wrap(int'(head_q), int'(cnt_q) + i)] <= push_data[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < POP_W; i++)
      peek[i] = slot_q[wrap(int'(head_q), i)];
  end

  always_comb begin
    cls_t c;
    mem_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      c = cls_t'(slot_q[wrap(int'(head_q), i)][CLS_W-1:0]);
      if (i < int'(cnt_q) && (c.ld || c.st))
        mem_cnt = mem_cnt + 1'b1;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/dsp_route.sv
`timescale 1ns/1ps
module dsp_route
  import dsp_pkg::*;
(
  input  logic vld,
  input  cls_t cls,
  output logic iq,
  output logic ns,
  output logic lsq,
  output logic done,
  output logic mem
);
  route_t r;
  assign r    = route_of(vld, cls);
  assign iq   = r.iq;
  assign ns   = r.ns;
  assign lsq  = r.lsq;
  assign done = r.done;
  assign mem  = r.mem;
endmodule

// File: rtl/disp_skid_ctrl.sv
`timescale 1ns/1ps
module disp_skid_ctrl
  import dsp_pkg::*;
#(
  parameter  int REN_W   = 4,
  parameter  int ISSUE_W = 2,
  parameter  int REN_DLY = 1,
  parameter  int TAG_W   = 8,
  localparam int DEPTH   = skid_cap(REN_DLY, REN_W, ISSUE_W),
  localparam int CNT_W   = $clog2(DEPTH + REN_W + 1),
  localparam int E_W     = TAG_W + CLS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REN_W-1:0]         i_vld,
  input  logic [REN_W*TAG_W-1:0]   i_tag,
  input  logic [REN_W-1:0]         i_sq,
  input  logic [REN_W-1:0]         i_ld,
  input  logic [REN_W-1:0]         i_st,
  input  logic [REN_W-1:0]         i_sc,
  input  logic [REN_W-1:0]         i_ns,
  input  logic [REN_W-1:0]         i_nop,
  input  logic                     i_iq_full,
  input  logic                     i_lsq_full,
  input  logic                     i_lsq_stall,
  input  logic                     i_cmt_block,
  input  logic                     i_cmt_unblock,
  input  logic                     i_cmt_squash,
  input  logic                     i_rob_squashing,
  output logic [ISSUE_W-1:0]       o_iq_ins,
  output logic [ISSUE_W-1:0]       o_ns_ins,
  output logic [ISSUE_W-1:0]       o_lsq_ins,
  output logic [ISSUE_W-1:0]       o_nop_done,
  output logic [ISSUE_W*TAG_W-1:0] o_slot_tag,
  output logic                     o_block,
  output logic                     o_unblock,
  output logic [CNT_W-1:0]         o_disp_cnt,
  output logic [CNT_W-1:0]         o_mem_cnt,
  output logic [2:0]               o_state
);
  // ---------------- input lanes
  logic [REN_W-1:0][E_W-1:0] in_arr;
  logic [CNT_W-1:0]          n_in;
  logic [CNT_W-1:0]          in_mem;

  for (genvar g = 0; g < REN_W; g++) begin : g_lane
    assign in_arr[g] = {i_tag[g*TAG_W +: TAG_W],
                        i_sq[g], i_ld[g], i_st[g], i_sc[g], i_ns[g], i_nop[g]};
  end

  always_comb begin
    n_in   = '0;
    in_mem = '0;
    for (int i = 0; i < REN_W; i++) begin
      if (i_vld[i]) n_in = n_in + 1'b1;
      if (i_vld[i] && (i_ld[i] || i_st[i])) in_mem = in_mem + 1'b1;
    end
  end

  // ---------------- commit stall flag
  logic stall_now, stall_q, stall_any;

  dsp_stall u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_p    (i_cmt_block),
    .unblk_p  (i_cmt_unblock),
    .flag_now (stall_now),
    .flag_q   (stall_q)
  );

  assign stall_any = stall_now | i_iq_full | i_lsq_full | i_lsq_stall;

  // ---------------- skid buffer
  logic                        flush;
  logic [CNT_W-1:0]            pop_n, push_n;
  int                          push_off;
  logic [REN_W-1:0][E_W-1:0]   push_data;
  logic [ISSUE_W-1:0][E_W-1:0] peek;
  logic [CNT_W-1:0]            skid_cnt, skid_mem;

  dsp_skid #(
    .DEPTH (DEPTH), .PUSH_W(REN_W), .POP_W(ISSUE_W), .E_W(E_W), .CNT_W(CNT_W)
  ) u_skid (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .pop_n     (pop_n),
    .push_n    (push_n),
    .push_data (push_data),
    .peek      (peek),
    .count     (skid_cnt),
    .mem_cnt   (skid_mem)
  );

  always_comb begin
    for (int i = 0; i < REN_W; i++) begin
      int j;
      j = i + push_off;
      push_data[i] = (j < REN_W) ? in_arr[j] : '0;
    end
  end

  // ---------------- status decision
  dsp_state_e st_q, nxt_state;
  logic       blk_d, unblk_d, use_skid;
  int         take;
  logic [CNT_W-1:0] disp_d, mem_d;

  always_comb begin
    dsp_state_e cur;
    nxt_state = st_q;
    blk_d     = 1'b0;
    unblk_d   = 1'b0;
    flush     = 1'b0;
    pop_n     = '0;
    push_n    = '0;
    push_off  = 0;
    use_skid  = 1'b0;
    take      = 0;
    disp_d    = '0;
    cur       = st_q;
    if (i_cmt_squash) begin
      flush     = 1'b1;
      disp_d    = skid_cnt + n_in;
      unblk_d   = (st_q == ST_BLK) || (st_q == ST_UNB);
      nxt_state = ST_SQ;
    end else if (i_rob_squashing) begin
      disp_d    = n_in;
      nxt_state = ST_SQ;
    end else if (stall_any) begin
      push_n    = n_in;
      blk_d     = !((st_q == ST_BLK) || (st_q == ST_UNB));
      nxt_state = ST_BLK;
    end else begin
      if (st_q == ST_BLK) begin
        if (skid_cnt == '0) begin
          cur     = ST_RUN;
          unblk_d = 1'b1;
        end else begin
          cur = ST_UNB;
        end
      end else if (st_q == ST_SQ) begin
        cur = ST_RUN;
      end
      nxt_state = cur;
      if (cur == ST_UNB) begin
        use_skid = 1'b1;
        take     = min_int(int'(skid_cnt), ISSUE_W);
        pop_n    = CNT_W'(take);
        push_n   = n_in;
        if (int'(skid_cnt) > take) begin
          nxt_state = ST_BLK;
        end else if (n_in == '0) begin
          unblk_d   = 1'b1;
          nxt_state = ST_RUN;
        end
      end else begin
        take = min_int(int'(n_in), ISSUE_W);
        if (int'(n_in) > take) begin
          push_off  = take;
          push_n    = n_in - CNT_W'(take);
          blk_d     = 1'b1;
          unblk_d   = 1'b0;
          nxt_state = ST_BLK;
        end else if (take > 0) begin
          nxt_state = ST_RUN;
        end
      end
      disp_d = CNT_W'(take);
    end
  end

  // ---------------- per-slot routing
  logic [ISSUE_W-1:0][E_W-1:0] src;
  logic [ISSUE_W-1:0] rt_iq, rt_ns, rt_lsq, rt_done, rt_mem;

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    if (s < REN_W) begin : g_both
      assign src[s] = use_skid ? peek[s] : in_arr[s];
    end else begin : g_skid_only
      assign src[s] = use_skid ? peek[s] : '0;
    end
    dsp_route u_route (
      .vld  (s < take),
      .cls  (cls_t'(src[s][CLS_W-1:0])),
      .iq   (rt_iq[s]),
      .ns   (rt_ns[s]),
      .lsq  (rt_lsq[s]),
      .done (rt_done[s]),
      .mem  (rt_mem[s])
    );
  end

  always_comb begin
    logic [CNT_W-1:0] slot_mem;
    slot_mem = '0;
    for (int i = 0; i < ISSUE_W; i++)
      slot_mem = slot_mem + CNT_W'(rt_mem[i]);
    if (i_cmt_squash)         mem_d = skid_mem + in_mem;
    else if (i_rob_squashing) mem_d = in_mem;
    else                      mem_d = slot_mem;
  end

  // ---------------- registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      o_iq_ins   <= '0;
      o_ns_ins   <= '0;
      o_lsq_ins  <= '0;
      o_nop_done <= '0;
      o_slot_tag <= '0;
      o_block    <= 1'b0;
      o_unblock  <= 1'b0;
      o_disp_cnt <= '0;
      o_mem_cnt  <= '0;
    end else begin
      st_q       <= nxt_state;
      o_iq_ins   <= rt_iq;
      o_ns_ins   <= rt_ns;
      o_lsq_ins  <= rt_lsq;
      o_nop_done <= rt_done;
      for (int i = 0; i < ISSUE_W; i++)
        o_slot_tag[i*TAG_W +: TAG_W] <= src[i][E_W-1:CLS_W];
      o_block    <= blk_d;
      o_unblock  <= unblk_d;
      o_disp_cnt <= disp_d;
      o_mem_cnt  <= mem_d;
    end
  end

  assign o_state = st_q;
endmodule

// File: rtl/disp_skid_ctrl_chk.sv
`timescale 1ns/1ps
module disp_skid_ctrl_chk
  import dsp_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int DEPTH   = 14,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               o_block,
  input logic               o_unblock,
  input logic [2:0]         o_state,
  input logic [CNT_W-1:0]   o_disp_cnt,
  input logic [CNT_W-1:0]   skid_cnt,
  input logic               stall_q,
  input logic               cmt_block,
  input logic               cmt_unblock,
  input logic [ISSUE_W-1:0] iq_s,
  input logic [ISSUE_W-1:0] ns_s,
  input logic [ISSUE_W-1:0] lsq_s,
  input logic [ISSUE_W-1:0] done_s
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_block && o_unblock)); // R5

  AST_BLOCK_MEANS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    o_block |-> (o_state == 3'(ST_BLK))); // R6

  AST_NO_REBLOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_state == 3'(ST_BLK) && $past(o_state) == 3'(ST_UNB)) |-> !o_block); // R6

  AST_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    o_unblock |-> (skid_cnt == '0)); // R8

  AST_SKID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(skid_cnt) <= DEPTH); // R12

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (o_state == 3'(ST_SQ)) |-> ((iq_s | ns_s | lsq_s | done_s) == '0)); // R9

  AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (o_state != 3'(ST_SQ)) |-> (int'(o_disp_cnt) <= ISSUE_W)); // R2

  AST_CMT_RELEASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_unblock |-> (stall_q || cmt_block)); // R7
endmodule

bind disp_skid_ctrl disp_skid_ctrl_chk #(
  .ISSUE_W(ISSUE_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .o_block    (o_block),
  .o_unblock  (o_unblock),
  .o_state    (o_state),
  .o_disp_cnt (o_disp_cnt),
  .skid_cnt   (skid_cnt),
  .stall_q    (stall_q),
  .cmt_block  (i_cmt_block),
  .cmt_unblock(i_cmt_unblock),
  .iq_s       (o_iq_ins),
  .ns_s       (o_ns_ins),
  .lsq_s      (o_lsq_ins),
  .done_s     (o_nop_done)
);

// File: tb/disp_skid_ctrl_tb.sv
`timescale 1ns/1ps
module disp_skid_ctrl_tb;
  localparam int RW = 3;
  localparam int IW = 2;
  localparam int DL = 1;
  localparam int TW = 6;
  localparam int CAP = 3 * DL * RW + IW;
  localparam int CW = $clog2(CAP + RW + 1);

  localparam logic [5:0] PL = 6'h00, LD = 6'h10, ST = 6'h08, SQLD = 6'h30;

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] vld, sq, ld, st, sc, ns, nop;
  logic [RW*TW-1:0] tag;
  logic iq_full, lsq_full, lsq_stall, cblk, cunb, csq, rsq;
  logic [IW-1:0] o_iq, o_ns, o_lsq, o_done;
  logic [IW*TW-1:0] o_tag;
  logic o_block, o_unblock;
  logic [CW-1:0] o_disp, o_mem;
  logic [2:0] o_state;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  disp_skid_ctrl #(.REN_W(RW), .ISSUE_W(IW), .REN_DLY(DL), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .i_vld(vld), .i_tag(tag), .i_sq(sq), .i_ld(ld),
    .i_st(st), .i_sc(sc), .i_ns(ns), .i_nop(nop), .i_iq_full(iq_full),
    .i_lsq_full(lsq_full), .i_lsq_stall(lsq_stall), .i_cmt_block(cblk),
    .i_cmt_unblock(cunb), .i_cmt_squash(csq), .i_rob_squashing(rsq),
    .o_iq_ins(o_iq), .o_ns_ins(o_ns), .o_lsq_ins(o_lsq), .o_nop_done(o_done),
    .o_slot_tag(o_tag), .o_block(o_block), .o_unblock(o_unblock),
    .o_disp_cnt(o_disp), .o_mem_cnt(o_mem), .o_state(o_state));

  task automatic ck(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    vld = '0; sq = '0; ld = '0; st = '0; sc = '0; ns = '0; nop = '0; tag = '0;
    iq_full = 0; lsq_full = 0; lsq_stall = 0; cblk = 0; cunb = 0; csq = 0; rsq = 0;
  endtask

  task automatic put(int lane, int t, logic [5:0] c);
    vld[lane] = 1'b1;
    tag[lane*TW +: TW] = TW'(t);
    {sq[lane], ld[lane], st[lane], sc[lane], ns[lane], nop[lane]} = c;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int stag(int s);
    return int'(o_tag[s*TW +: TW]);
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    int exp_tag, left;
    clr();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    ck("R1 state", o_state, 0);
    ck("R1 disp", o_disp, 0);
    ck("R1 pulses", {o_block, o_unblock}, 0);
    ck("R1 strobes", {o_iq, o_ns, o_lsq, o_done}, 0);
    rst_n = 1;
    tick();

    // R2 idle to running
    put(0, 1, PL); tick(); clr();
    ck("R2 disp", o_disp, 1); ck("R2 iq", o_iq, 1); ck("R2 tag", stag(0), 1);
    ck("R2 state", o_state, 1);

    // R5 surplus
    put(0, 2, PL); put(1, 3, PL); put(2, 4, PL); tick(); clr();
    ck("R5 disp", o_disp, 2); ck("R5 tag0", stag(0), 2); ck("R5 tag1", stag(1), 3);
    ck("R5 block", o_block, 1); ck("R5 unblock", o_unblock, 0); ck("R5 state", o_state, 2);

    // R8 drain single
    tick();
    ck("R8 disp", o_disp, 1); ck("R8 tag", stag(0), 4); ck("R8 unblock", o_unblock, 1);
    ck("R8 state", o_state, 1);

    // R6 queue full parks input
    iq_full = 1; put(0, 5, PL); put(1, 6, PL); tick(); clr();
    ck("R6 block", o_block, 1); ck("R6 state", o_state, 2); ck("R6 disp", o_disp, 0);
    iq_full = 1; put(0, 7, PL); put(1, 8, PL); put(2, 9, PL); tick(); clr();
    ck("R6 no second pulse", o_block, 0); ck("R6 state2", o_state, 2);

    // R8 drain with append
    put(0, 10, PL); put(1, 11, PL); tick(); clr();
    ck("R8 d1", o_disp, 2); ck("R8 t5", stag(0), 5); ck("R8 t6", stag(1), 6);
    ck("R8 back blocked", o_state, 2); ck("R8 pulses", {o_block, o_unblock}, 0);
    tick(); ck("R8 t7", stag(0), 7); ck("R8 t8", stag(1), 8);
    tick(); ck("R8 t9", stag(0), 9); ck("R8 t10", stag(1), 10);
    tick(); ck("R8 t11", stag(0), 11); ck("R8 last disp", o_disp, 1);
    ck("R8 release", o_unblock, 1); ck("R8 running", o_state, 1);

    // R7 commit stall flag
    cblk = 1; tick(); clr();
    ck("R7 block", o_block, 1); ck("R7 state", o_state, 2);
    tick();
    ck("R7 held", o_state, 2); ck("R7 held pulses", {o_block, o_unblock}, 0);
    cunb = 1; put(0, 12, PL); tick(); clr();
    ck("R7 release", o_unblock, 1); ck("R7 running", o_state, 1); ck("R7 tag", stag(0), 12);
    cblk = 1; cunb = 1; put(0, 13, PL); tick(); clr();
    ck("R7 both release wins", o_state, 1); ck("R7 both disp", o_disp, 1);
    ck("R7 both no block", o_block, 0);

    // R9 squash with loaded buffer
    iq_full = 1; put(0, 14, LD); put(1, 15, PL); tick(); clr();
    ck("R9 pre", o_state, 2);
    csq = 1; iq_full = 1; put(0, 16, ST); tick(); clr();
    ck("R9 disp", o_disp, 3); ck("R9 mem", o_mem, 2); ck("R9 unblock", o_unblock, 1);
    ck("R9 block", o_block, 0); ck("R9 state", o_state, 4); ck("R9 iq", o_iq, 0);

    // R10 rob squashing
    rsq = 1; put(0, 17, LD); put(1, 18, PL); tick(); clr();
    ck("R10 disp", o_disp, 2); ck("R10 mem", o_mem, 1); ck("R10 state", o_state, 4);
    ck("R10 strobes", {o_iq, o_ns, o_lsq, o_done}, 0);

    // R11 back to running
    put(0, 19, PL); tick(); clr();
    ck("R11 state", o_state, 1); ck("R11 disp", o_disp, 1); ck("R11 tag", stag(0), 19);

    // R4 squashed instruction
    put(0, 20, SQLD); put(1, 21, PL); tick(); clr();
    ck("R4 disp", o_disp, 2); ck("R4 mem", o_mem, 1); ck("R4 iq", o_iq, 2);
    ck("R4 lsq", o_lsq, 0);

    // R13 quiet cycle
    tick();
    ck("R13 disp", o_disp, 0); ck("R13 mem", o_mem, 0);
    ck("R13 strobes", {o_iq, o_ns, o_lsq, o_done}, 0);

    // R9 squash while running
    csq = 1; tick(); clr();
    ck("R9 run unblock", o_unblock, 0); ck("R9 run state", o_state, 4);
    tick();
    ck("R11 idle return", o_state, 1);

    // R6 each queue stall source
    for (int s = 0; s < 3; s++) begin
      iq_full = (s == 0); lsq_full = (s == 1); lsq_stall = (s == 2);
      tick(); clr();
      ck("R6 src block", o_block, 1); ck("R6 src state", o_state, 2);
      tick();
      ck("R6 src release", o_unblock, 1); ck("R6 src running", o_state, 1);
    end

    // R12 fill to capacity, then drain in order
    exp_tag = 30;
    for (int c = 0; c < 4; c++) begin
      iq_full = 1;
      for (int l = 0; l < ((c == 3) ? CAP - 9 : 3); l++) put(l, exp_tag + c * 3 + l, PL);
      tick(); clr();
    end
    ck("R12 parked", o_state, 2);
    left = CAP;
    while (left > 0) begin
      int n;
      n = (left < IW) ? left : IW;
      tick();
      ck("R12 disp", o_disp, n);
      for (int s = 0; s < n; s++) begin
        ck("R12 order", stag(s), exp_tag);
        exp_tag++;
      end
      left -= n;
    end
    ck("R12 release", o_unblock, 1); ck("R12 running", o_state, 1);

    // R3 routing sweep
    for (int f = 0; f < 64; f++) begin
      bit fsq, fld, fst, fsc, fns, fnop, e_iq, e_ns, e_lsq, e_done;
      {fsq, fld, fst, fsc, fns, fnop} = 6'(f);
      e_lsq  = !fsq && (fld || fst);
      e_ns   = !fsq && !fld && (fst ? fsc : fns);
      e_done = !fsq && !fld && !fst && !fns && fnop;
      e_iq   = !fsq && (fld || (fst && !fsc) || (!fld && !fst && !fns && !fnop));
      put(0, f, 6'(f)); tick(); clr();
      ck("R3 route", {o_iq[0], o_ns[0], o_lsq[0], o_done[0]}, {e_iq, e_ns, e_lsq, e_done});
      ck("R4 mem", o_mem, int'(fld || fst));
      ck("R2 one", o_disp, 1);
    end

    finished = 1;
    report();
  end
endmodule